// File: doc/BRIEF.md
# Multi-Width Parallel Host Port

This block is the parallel host side of a coprocessor. A host moves 32-bit words into the core and 32-bit results out of it over an asynchronous strobe bus. The bus may be 8, 16 or 32 bits wide, and the width is chosen at run time by a 2-bit mode input. In the narrow modes a word is split into lanes, and the address selects the lane. Partial lanes collect in a staging register. The finished word goes to the core over a valid/ready handshake once its last lane arrives.

The same address space holds a command register and a 16-bit status register. A command byte must carry a tag bit to be taken. The status register appears at one address in the wide modes and at two addresses in byte mode. BUSY tells the host that a word or command is waiting for the core. INT tells the host that a result word is ready to read.

The host strobes are asynchronous, so they pass through a synchronizer and are acted on at their edges. The read data path is combinational from the address pins, so read data is valid for the whole access.

Top module: `hostWidthPort`

## Requirements
- R1: `widthMode` encoding: 2'b11 is 32-bit, 2'b10 is 16-bit and 2'b01 is 8-bit. 2'b00 hands the bus to a serial port: parallel writes have no effect and `hostDataOutEn` stays low.
- R2: 8-bit mode. A write uses `hostDataIn[7:0]`. Addresses 0, 1, 2 and 3 carry word bits 7:0, 15:8, 23:16 and 31:24.
- R3: 16-bit mode. A write uses `hostDataIn[15:0]`. Address 0 carries bits 15:0 and address 1 carries bits 31:16.
- R4: 32-bit mode. One write at address 0 carries the whole word from `hostDataIn[31:0]`.
- R5: A word is offered to the core (`coreWordValid`) only after its final lane is written: address 3, 1 or 0 in 8-, 16- or 32-bit mode. Earlier lanes only fill the staging register.
- R6: A write to address 4 with bit 7 set issues a command, and `coreCmd` takes bits 6:0. With bit 7 clear the write is ignored. A pending command holds `coreCmd` stable until `coreCmdReady`.
- R7: In 16- and 32-bit modes, a read of address 4 returns the 16-bit status on bits 15:0. In 8-bit mode, address 4 returns status bits 7:0 and address 5 returns bits 15:8.
- R8: `hostDataOutEn` is high only while CE and OE are both low in a parallel mode. While it is low, `hostDataOut` is zero.
- R9: `intReq` rises when a result word is loaded. A read of a non-final lane leaves it set. It clears after the read of the final lane (the same addresses as R5) ends.
- R10: `busy` is high from the hand-off of a word or command until the core takes it. The offered word is held stable meanwhile.
- R11: Data and command writes made while `busy` is high are ignored.
- R12: Result reads use the same lane map as writes: R2, R3 and R4 applied to `hostDataOut`.
- R13: When a new result is already offered, it is loaded in the same cycle that the final-lane read frees the result register. `intReq` then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| widthMode | input | 2 | Bus width select (R1) |
| hostAddr | input | 3 | Host address |
| hostCeN | input | 1 | Chip enable, active low |
| hostWrN | input | 1 | Write strobe, active low |
| hostOeN | input | 1 | Output enable, active low |
| hostDataIn | input | 32 | Host write data |
| hostDataOut | output | 32 | Host read data |
| hostDataOutEn | output | 1 | Read data driver enable |
| busy | output | 1 | Word or command awaiting the core |
| intReq | output | 1 | Result word available |
| coreWordValid | output | 1 | Assembled word offered to the core |
| coreWordReady | input | 1 | Core takes the word |
| coreWordData | output | 32 | Assembled word |
| coreCmdValid | output | 1 | Command offered to the core |
| coreCmdReady | input | 1 | Core takes the command |
| coreCmd | output | 7 | Command code |
| coreStatus | input | 16 | Core status word |
| resultValid | input | 1 | Core offers a result word |
| resultReady | output | 1 | Port accepts the result word |
| resultData | input | 32 | Result word from the core |

## Verification
The host's read of the last result lane and the core's offer of the next result can meet in one clock. That cycle both frees the result register and refills it. To provoke it, the bench parks a second result on `resultValid` while the first is still held, with `resultReady` seen low, and then reads the first word lane by lane. The check is that the first read returns the old word and `intReq` never drops. A further read then returns the new word, and only the final lane of that read clears `intReq`.

// File: rtl/hpPkg.sv
package hpPkg;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] CMD_ADDR   = 3'b100;
  localparam logic [ADDR_W-1:0] STATHI_ADDR = 3'b101;

  typedef enum logic [1:0] {
    MODE_SERIAL = 2'b00,
    MODE_BYTE   = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_WORD   = 2'b11
  } widthMode_t;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic       laneWe;
    logic [1:0] laneIdx;
    logic       pushWord;
    logic       pushCmd;
    logic       loadResult;
  } hpStrobes_t;

  function automatic logic laneValid(input logic [1:0] mode, input logic [ADDR_W-1:0] addr);
    case (mode)
      MODE_BYTE: laneValid = (addr < 3'd4);
      MODE_HALF: laneValid = (addr < 3'd2);
      MODE_WORD: laneValid = (addr == 3'd0);
      default:   laneValid = 1'b0;
    endcase
  endfunction

  function automatic logic laneFinal(input logic [1:0] mode, input logic [ADDR_W-1:0] addr);
    case (mode)
      MODE_BYTE: laneFinal = (addr == 3'd3);
      MODE_HALF: laneFinal = (addr == 3'd1);
      MODE_WORD: laneFinal = (addr == 3'd0);
      default:   laneFinal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/hpControl.sv
module hpControl
  import hpPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        widthMode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostCeN,
  input  logic              hostWrN,
  input  logic              hostOeN,
  input  logic              cmdTag,
  input  logic              coreWordReady,
  input  logic              coreCmdReady,
  input  logic              resultValid,
  output hpStrobes_t        strobes,
  output logic              wordValid,
  output logic              cmdValid,
  output logic              resultFull,
  output logic              resultReady
);

  localparam int LAST = SYNC_STAGES - 1;

  // synchronizer for {ce, wr, oe}
  logic [2:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= 3'b111;
    end else begin
      syncQ[0] <= {hostCeN, hostWrN, hostOeN};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  logic wrAct, rdAct, wrPrev, rdPrev;
  logic wrStart, rdStart, rdEnd;
  logic [ADDR_W-1:0] rdAddr;
  logic modeOn, busyNow, popResult;

  assign wrAct   = !syncQ[LAST][2] && !syncQ[LAST][1];
  assign rdAct   = !syncQ[LAST][2] && !syncQ[LAST][0];
  assign wrStart = wrAct && !wrPrev;
  assign rdStart = rdAct && !rdPrev;
  assign rdEnd   = !rdAct && rdPrev;
  assign modeOn  = (widthMode != MODE_SERIAL);
  assign busyNow = wordValid || cmdValid;

  always_comb begin
    strobes          = '0;
    strobes.laneIdx  = hostAddr[1:0];
    strobes.laneWe   = wrStart && modeOn && !busyNow && laneValid(widthMode, hostAddr);
    strobes.pushWord = strobes.laneWe && laneFinal(widthMode, hostAddr);
    strobes.pushCmd  = wrStart && modeOn && !busyNow && (hostAddr == CMD_ADDR) && cmdTag;
    strobes.loadResult = resultValid && resultReady;
  end

  assign popResult   = rdEnd && resultFull && modeOn && laneFinal(widthMode, rdAddr);
  assign resultReady = !resultFull || popResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev     <= 1'b0;
      rdPrev     <= 1'b0;
      rdAddr     <= '0;
      wordValid  <= 1'b0;
      cmdValid   <= 1'b0;
      resultFull <= 1'b0;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;
      if (rdStart) rdAddr <= hostAddr;

      if (strobes.pushWord)   wordValid <= 1'b1;
      else if (coreWordReady) wordValid <= 1'b0;

      if (strobes.pushCmd)    cmdValid <= 1'b1;
      else if (coreCmdReady)  cmdValid <= 1'b0;

      if (strobes.loadResult) resultFull <= 1'b1;
      else if (popResult)     resultFull <= 1'b0;
    end
  end

endmodule

// File: rtl/hpDatapath.sv
module hpDatapath
  import hpPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STATUS_W = 16,
  parameter int CMD_W    = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  hpStrobes_t          strobes,
  input  logic [1:0]          widthMode,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostCeN,
  input  logic                hostOeN,
  input  logic [DATA_W-1:0]   hostDataIn,
  input  logic [STATUS_W-1:0] coreStatus,
  input  logic [DATA_W-1:0]   resultData,
  output logic [DATA_W-1:0]   wordData,
  output logic [CMD_W-1:0]    cmdCode,
  output logic [DATA_W-1:0]   hostDataOut,
  output logic                hostDataOutEn
);

  localparam int BYTES = DATA_W / 8;
  localparam int HALF  = DATA_W / 2;

  logic [DATA_W-1:0] stageReg, stageNext, resultReg;

  // merge of the incoming lane into the staged word
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic hit8, hit16, hit32;
    assign hit8  = strobes.laneWe && widthMode == MODE_BYTE && strobes.laneIdx == 2'(b);
    assign hit16 = strobes.laneWe && widthMode == MODE_HALF && strobes.laneIdx == 2'(b / 2);
    assign hit32 = strobes.laneWe && widthMode == MODE_WORD;
    assign stageNext[b*8 +: 8] =
      hit8  ? hostDataIn[7:0] :
      hit16 ? hostDataIn[(b % 2)*8 +: 8] :
      hit32 ? hostDataIn[b*8 +: 8] :
              stageReg[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageReg  <= '0;
      wordData  <= '0;
      cmdCode   <= '0;
      resultReg <= '0;
    end else begin
      if (strobes.laneWe)     stageReg  <= stageNext;
      if (strobes.pushWord)   wordData  <= stageNext;
      if (strobes.pushCmd)    cmdCode   <= hostDataIn[CMD_W-1:0];
      if (strobes.loadResult) resultReg <= resultData;
    end
  end

  assign hostDataOutEn = !hostCeN && !hostOeN && (widthMode != MODE_SERIAL);

  always_comb begin
    hostDataOut = '0;
    if (hostDataOutEn) begin
      case (widthMode)
        MODE_BYTE: begin
          if (hostAddr < 3'd4)              hostDataOut[7:0] = resultReg[hostAddr[1:0]*8 +: 8];
          else if (hostAddr == CMD_ADDR)    hostDataOut[7:0] = coreStatus[7:0];
          else if (hostAddr == STATHI_ADDR) hostDataOut[7:0] = coreStatus[15:8];
        end
        MODE_HALF: begin
          if (hostAddr < 3'd2)           hostDataOut[HALF-1:0] = resultReg[hostAddr[0]*HALF +: HALF];
          else if (hostAddr == CMD_ADDR) hostDataOut[STATUS_W-1:0] = coreStatus;
        end
        MODE_WORD: begin
          if (hostAddr == 3'd0)          hostDataOut = resultReg;
          else if (hostAddr == CMD_ADDR) hostDataOut[STATUS_W-1:0] = coreStatus;
        end
        default: hostDataOut = '0;
      endcase
    end
  end

endmodule

// File: rtl/hostWidthPort.sv
module hostWidthPort
  import hpPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int STATUS_W    = 16,
  parameter int CMD_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          widthMode,
  input  logic [2:0]          hostAddr,
  input  logic                hostCeN,
  input  logic                hostWrN,
  input  logic                hostOeN,
  input  logic [DATA_W-1:0]   hostDataIn,
  output logic [DATA_W-1:0]   hostDataOut,
  output logic                hostDataOutEn,
  output logic                busy,
  output logic                intReq,
  output logic                coreWordValid,
  input  logic                coreWordReady,
  output logic [DATA_W-1:0]   coreWordData,
  output logic                coreCmdValid,
  input  logic                coreCmdReady,
  output logic [CMD_W-1:0]    coreCmd,
  input  logic [STATUS_W-1:0] coreStatus,
  input  logic                resultValid,
  output logic                resultReady,
  input  logic [DATA_W-1:0]   resultData
);

  hpStrobes_t strobes;
  logic wordValid, cmdValid, resultFull;

  hpControl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .widthMode(widthMode), .hostAddr(hostAddr),
    .hostCeN(hostCeN), .hostWrN(hostWrN), .hostOeN(hostOeN),
    .cmdTag(hostDataIn[7]), .coreWordReady(coreWordReady),
    .coreCmdReady(coreCmdReady), .resultValid(resultValid),
    .strobes(strobes), .wordValid(wordValid), .cmdValid(cmdValid),
    .resultFull(resultFull), .resultReady(resultReady)
  );

  hpDatapath #(.DATA_W(DATA_W), .STATUS_W(STATUS_W), .CMD_W(CMD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .widthMode(widthMode),
    .hostAddr(hostAddr), .hostCeN(hostCeN), .hostOeN(hostOeN),
    .hostDataIn(hostDataIn), .coreStatus(coreStatus), .resultData(resultData),
    .wordData(coreWordData), .cmdCode(coreCmd),
    .hostDataOut(hostDataOut), .hostDataOutEn(hostDataOutEn)
  );

  assign coreWordValid = wordValid;
  assign coreCmdValid  = cmdValid;
  assign busy          = wordValid || cmdValid;
  assign intReq        = resultFull;

endmodule

// File: rtl/hostWidthPortChecker.sv
module hostWidthPortChecker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  widthMode,
  input logic [31:0] hostDataOut,
  input logic        hostDataOutEn,
  input logic        busy,
  input logic        intReq,
  input logic        coreWordValid,
  input logic        coreWordReady,
  input logic [31:0] coreWordData,
  input logic        coreCmdValid,
  input logic        coreCmdReady,
  input logic [6:0]  coreCmd,
  input logic        resultValid,
  input logic        resultReady
);

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    coreWordValid && !coreWordReady |=> coreWordValid && $stable(coreWordData));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    coreCmdValid && !coreCmdReady |=> coreCmdValid && $stable(coreCmd));

  assert_busy_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    (coreWordValid || coreCmdValid) |-> busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !coreWordValid && !coreCmdValid);

  assert_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hostDataOutEn |-> hostDataOut == 32'd0);

  assert_serial_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    widthMode == 2'b00 |-> !hostDataOutEn);

  assert_load_int_R9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && resultReady |=> intReq);

  assert_ready_free_R13: assert property (@(posedge clk) disable iff (!rstN)
    !intReq |-> resultReady);

endmodule

bind hostWidthPort hostWidthPortChecker chk (
  .clk(clk), .rstN(rstN), .widthMode(widthMode), .hostDataOut(hostDataOut),
  .hostDataOutEn(hostDataOutEn), .busy(busy), .intReq(intReq),
  .coreWordValid(coreWordValid), .coreWordReady(coreWordReady),
  .coreWordData(coreWordData), .coreCmdValid(coreCmdValid),
  .coreCmdReady(coreCmdReady), .coreCmd(coreCmd),
  .resultValid(resultValid), .resultReady(resultReady)
);

// File: tb/tb_hostWidthPort.sv
module tb_hostWidthPort;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  widthMode = 2'b11;
  logic [2:0]  hostAddr = 3'd0;
  logic        hostCeN = 1'b1, hostWrN = 1'b1, hostOeN = 1'b1;
  logic [31:0] hostDataIn = 32'd0;
  logic [31:0] hostDataOut;
  logic        hostDataOutEn, busy, intReq;
  logic        coreWordValid, coreCmdValid, resultReady;
  logic        coreWordReady = 1'b0, coreCmdReady = 1'b0;
  logic [31:0] coreWordData;
  logic [6:0]  coreCmd;
  logic [15:0] coreStatus = 16'hA5C3;
  logic        resultValid = 1'b0;
  logic [31:0] resultData = 32'd0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  hostWidthPort dut (
    .clk(clk), .rstN(rstN), .widthMode(widthMode), .hostAddr(hostAddr),
    .hostCeN(hostCeN), .hostWrN(hostWrN), .hostOeN(hostOeN),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOutEn(hostDataOutEn),
    .busy(busy), .intReq(intReq), .coreWordValid(coreWordValid),
    .coreWordReady(coreWordReady), .coreWordData(coreWordData),
    .coreCmdValid(coreCmdValid), .coreCmdReady(coreCmdReady), .coreCmd(coreCmd),
    .coreStatus(coreStatus), .resultValid(resultValid), .resultReady(resultReady),
    .resultData(resultData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side lane model: lanes per word and lane value for a mode
  function automatic int laneCount(input logic [1:0] m);
    return (m == 2'b01) ? 4 : (m == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic [31:0] laneBus(input logic [1:0] m, input logic [31:0] w,
                                          input int k, input logic [31:0] junk);
    case (m)
      2'b01:   return {junk[31:8], w[k*8 +: 8]};
      2'b10:   return {junk[31:16], w[k*16 +: 16]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] laneRead(input logic [1:0] m, input logic [31:0] w, input int k);
    case (m)
      2'b01:   return {24'd0, w[k*8 +: 8]};
      2'b10:   return {16'd0, w[k*16 +: 16]};
      default: return w;
    endcase
  endfunction

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostDataIn = d; hostCeN = 0; hostWrN = 0;
    repeat (5) @(negedge clk);
    hostCeN = 1; hostWrN = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [31:0] d, output logic en);
    @(negedge clk);
    hostAddr = a; hostCeN = 0; hostOeN = 0;
    repeat (4) @(negedge clk);
    d = hostDataOut; en = hostDataOutEn;
    hostCeN = 1; hostOeN = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic writeWord(input logic [1:0] m, input logic [31:0] w);
    widthMode = m;
    for (int k = 0; k < laneCount(m); k++) hostWrite(3'(k), laneBus(m, w, k, $urandom));
  endtask

  task automatic readWord(input logic [1:0] m, output logic [31:0] w, output logic okLanes);
    logic [31:0] d; logic en;
    widthMode = m; w = 0; okLanes = 1;
    for (int k = 0; k < laneCount(m); k++) begin
      hostRead(3'(k), d, en);
      if (!en) okLanes = 0;
      case (m)
        2'b01: begin if (d[31:8] != 0) okLanes = 0; w[k*8 +: 8] = d[7:0]; end
        2'b10: begin if (d[31:16] != 0) okLanes = 0; w[k*16 +: 16] = d[15:0]; end
        default: w = d;
      endcase
    end
  endtask

  task automatic pushResult(input logic [31:0] d);
    @(negedge clk);
    resultValid = 1; resultData = d;
    #1;
    while (!resultReady) begin @(negedge clk); #1; end
    @(negedge clk);
    resultValid = 0;
  endtask

  task automatic acceptWord();
    @(negedge clk); coreWordReady = 1;
    @(negedge clk); coreWordReady = 0;
  endtask

  task automatic acceptCmd();
    @(negedge clk); coreCmdReady = 1;
    @(negedge clk); coreCmdReady = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w, exp;
    logic en, ok;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // reset state
    check("R10 reset busy", {31'd0, busy}, 0);
    check("R9 reset int", {31'd0, intReq}, 0);
    check("R8 reset oe", {31'd0, hostDataOutEn}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2 / R5: byte mode, partial lanes do not hand off
    widthMode = 2'b01;
    exp = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) hostWrite(3'(k), laneBus(2'b01, exp, k, 32'hFFFF_FF00));
    check("R5 partial no valid", {31'd0, coreWordValid}, 0);
    hostWrite(3'd3, laneBus(2'b01, exp, 3, 32'h1234_5600));
    check("R5 final valid", {31'd0, coreWordValid}, 1);
    check("R2 byte assembly", coreWordData, exp);
    check("R10 busy while pending", {31'd0, busy}, 1);

    // R11: writes while busy are ignored
    hostWrite(3'd4, 32'h0000_0085);
    check("R11 cmd ignored busy", {31'd0, coreCmdValid}, 0);
    widthMode = 2'b11;
    hostWrite(3'd0, 32'h0BAD_F00D);
    check("R11 data ignored busy", coreWordData, exp);
    acceptWord();
    check("R10 busy released", {31'd0, busy}, 0);
    check("R10 valid released", {31'd0, coreWordValid}, 0);

    // R3 half mode, R4 word mode
    writeWord(2'b10, 32'hCAFE_1234);
    check("R3 half assembly", coreWordData, 32'hCAFE_1234);
    acceptWord();
    writeWord(2'b11, 32'h0102_0304);
    check("R4 word assembly", coreWordData, 32'h0102_0304);
    acceptWord();

    // R6 commands
    widthMode = 2'b10;
    hostWrite(3'd4, 32'hFFFF_FF93);
    check("R6 cmd valid", {31'd0, coreCmdValid}, 1);
    check("R6 cmd code", {25'd0, coreCmd}, 32'h13);
    check("R10 busy on cmd", {31'd0, busy}, 1);
    acceptCmd();
    hostWrite(3'd4, 32'h0000_0015);
    check("R6 untagged ignored", {31'd0, coreCmdValid}, 0);
    check("R6 untagged code kept", {25'd0, coreCmd}, 32'h13);

    // R7 status
    widthMode = 2'b11; hostRead(3'd4, d, en);
    check("R7 status word", d, 32'h0000_A5C3);
    widthMode = 2'b10; hostRead(3'd4, d, en);
    check("R7 status half", d, 32'h0000_A5C3);
    widthMode = 2'b01; hostRead(3'd4, d, en);
    check("R7 status low byte", d, 32'h0000_00C3);
    hostRead(3'd5, d, en);
    check("R7 status high byte", d, 32'h0000_00A5);
    check("R8 oe during read", {31'd0, en}, 1);
    check("R8 oe after read", {31'd0, hostDataOutEn}, 0);

    // R1 serial mode
    widthMode = 2'b00;
    hostWrite(3'd0, 32'h5555_AAAA);
    check("R1 serial write ignored", {31'd0, coreWordValid}, 0);
    hostRead(3'd4, d, en);
    check("R1 serial oe low", {31'd0, en}, 0);
    check("R1 serial data zero", d, 0);

    // R9 / R12 result path in byte mode
    pushResult(32'h89AB_CDEF);
    check("R9 int on load", {31'd0, intReq}, 1);
    widthMode = 2'b01; hostRead(3'd0, d, en);
    check("R12 byte lane0", d, 32'h0000_00EF);
    check("R9 non-final keeps int", {31'd0, intReq}, 1);
    readWord(2'b01, w, ok);
    check("R12 byte read word", w, 32'h89AB_CDEF);
    check("R12 byte upper zero", {31'd0, ok}, 1);
    check("R9 int cleared", {31'd0, intReq}, 0);

    // R13 same-cycle pop and reload
    pushResult(32'h1111_2222);
    @(negedge clk);
    resultValid = 1; resultData = 32'h3333_4444;
    #1;
    check("R13 ready low when full", {31'd0, resultReady}, 0);
    widthMode = 2'b11; hostRead(3'd0, d, en);
    check("R13 old word read", d, 32'h1111_2222);
    check("R13 int stays", {31'd0, intReq}, 1);
    @(negedge clk); resultValid = 0;
    hostRead(3'd0, d, en);
    check("R13 new word read", d, 32'h3333_4444);
    check("R9 int cleared after reload", {31'd0, intReq}, 0);

    // random mix over all parallel modes
    for (int n = 0; n < 16; n++) begin
      logic [1:0] m;
      logic [31:0] x;
      m = 2'(($urandom % 3) + 1);
      x = $urandom;
      writeWord(m, x);
      check("R5 random word valid", {31'd0, coreWordValid}, 1);
      check("R2/R3/R4 random word", coreWordData, x);
      acceptWord();
      x = $urandom;
      pushResult(x);
      readWord(m, w, ok);
      check("R12 random result", w, x);
      check("R12 random lanes", {31'd0, ok}, 1);
      check("R9 random int clear", {31'd0, intReq}, 0);
      d = laneRead(m, x, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule